// File: doc/BRIEF.md
# Sync and Blank Level Controller

This block turns the per-clock video timing controls of a three-channel video output path into a per-channel drive decision. Every cycle it samples an active-low blank request, an active-low sync request and an active-high positive-sync qualifier, together with three pixel words. For each channel (G/Y, Pb/B, Pr/R) it produces a 2-bit level selector and the digital code that the converter stage should apply. Sync wins over blanking. Sync is placed either on the G/Y channel alone or on all three channels. The blanking code depends on the channel and the insertion setting.

A single shared configuration pin carries two settings. The direction of the most recent edge on the sync request decides which setting the pin loads. The pin is read on the second rising clock edge after that edge. A falling sync edge loads the all-channel insertion flag, and a rising sync edge loads the mode bit. A sticky valid flag shows that the mode bit has been loaded at least once since reset. The level and code decisions pass through a configurable alignment delay, so they line up with a separate pixel data path.

Top module: `sync_blank_ctrl`

## Requirements
- R1: Controls and pixels present before rising edge k appear at the level/code outputs right after rising edge k+ALIGN_DLY (default 2), and not earlier.
- R2: With blank_n high and sync_n high, every channel outputs level 00 (video) and its code equals that channel's pixel.
- R3: With blank_n low and sync_n high, every channel outputs level 01 (blank) and its blanking code, whatever the pixels.
- R4: With sync_n low, G/Y outputs a sync level (10 or 11), whatever blank_n and the pixels.
- R5: While sync_n is low, sync_pos high selects level 11 (positive sync) and sync_pos low selects level 10 (negative sync). While sync_n is high, sync_pos has no effect.
- R6: With ins_all = 1, all three channels take the sync level during sync. With ins_all = 0, Pb and Pr show level 01 with their blanking code during sync.
- R7: The G/Y blanking code is 0. The Pb/Pr blanking code is 128 when ins_all = 1 and 0 when ins_all = 0; setting FORCE_MID = 1 makes it 128 always. A channel at a sync or blank level carries its blanking code.
- R8: mode_pin is sampled only on the second rising edge after a change of sync_n. After a high-to-low change it loads ins_all, and after a low-to-high change it loads mode_bit. At all other times mode_pin is ignored.
- R9: After reset, ins_all, mode_bit and cfg_valid are 0 and all channels show level 01 with code 0.
- R10: cfg_valid rises on the first mode_bit load and then stays high until reset. An ins_all load does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| blank_n | input | 1 | Blank request, active low |
| sync_n | input | 1 | Sync request, active low |
| sync_pos | input | 1 | Positive-sync qualifier, used only during sync |
| mode_pin | input | 1 | Shared configuration pin |
| pix_gy | input | DW | G/Y pixel |
| pix_pb | input | DW | Pb/B pixel |
| pix_pr | input | DW | Pr/R pixel |
| lvl_gy | output | 2 | G/Y level: 00 video, 01 blank, 10 negative sync, 11 positive sync |
| lvl_pb | output | 2 | Pb/B level, same encoding |
| lvl_pr | output | 2 | Pr/R level, same encoding |
| code_gy | output | DW | G/Y code to apply |
| code_pb | output | DW | Pb/B code to apply |
| code_pr | output | DW | Pr/R code to apply |
| ins_all | output | 1 | Sync inserted on all channels |
| mode_bit | output | 1 | Loaded mode bit |
| cfg_valid | output | 1 | Mode bit loaded at least once |

## Verification
A wrong pending-capture state loads mode_pin one edge early or late, or into the wrong flag. ins_all, mode_bit or cfg_valid then differ from the expected value on the very next cycle. The wrong flag also shows ALIGN_DLY+1 cycles later as a Pb/Pr level that has or lacks sync, or as a blanking code that is 0 instead of 128. A wrong alignment pipeline or wrong precedence logic shows as a level or code mismatch on the first cycle that the affected vector reaches the outputs. Random sync windows of varied length are mixed with random mode_pin values, so both capture directions and both insertion settings are exercised many times.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [1:0] {
        LVL_VIDEO    = 2'b00,
        LVL_BLANK    = 2'b01,
        LVL_SYNC_NEG = 2'b10,
        LVL_SYNC_POS = 2'b11
    } lvl_e;

    localparam int NCH   = 3;
    localparam int CH_GY = 0;
    localparam int CH_PB = 1;
    localparam int CH_PR = 2;
endpackage

// File: rtl/sbc_cfg_capture.sv
module sbc_cfg_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic mode_pin,
    output logic ins_all,
    output logic mode_bit,
    output logic cfg_valid
);
    typedef struct packed {
        logic sync_last;   // sync_n as seen at the previous edge
        logic pend;        // capture due at the next edge
        logic pend_rise;   // direction of the pending capture
        logic ins;
        logic mode;
        logic valid;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sync_last = sync_n;
        st_d.pend      = (sync_n != st_q.sync_last);
        st_d.pend_rise = sync_n & ~st_q.sync_last;
        if (st_q.pend) begin
            if (st_q.pend_rise) begin
                st_d.mode  = mode_pin;
                st_d.valid = 1'b1;
            end else begin
                st_d.ins = mode_pin;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync_last: 1'b1, default: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ins_all   = st_q.ins;
    assign mode_bit  = st_q.mode;
    assign cfg_valid = st_q.valid;

    // R8: rising-edge capture loads the mode bit from the pin
    assert_mode_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.pend_rise) |=> (mode_bit == $past(mode_pin)));
    // R8: falling-edge capture loads the insertion flag from the pin
    assert_ins_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !st_q.pend_rise) |=> (ins_all == $past(mode_pin)));
    // R8: pin ignored when no capture is due
    assert_pin_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend |=> ($stable(ins_all) && $stable(mode_bit)));
    // R10: valid is sticky
    assert_valid_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_valid);
endmodule

// File: rtl/sbc_chan_sel.sv
module sbc_chan_sel
    import sbc_pkg::*;
#(
    parameter int DW        = 8,
    parameter bit IS_GY     = 1'b0,
    parameter bit FORCE_MID = 1'b0
) (
    input  logic          sync_act,
    input  logic          sync_pos,
    input  logic          blank_act,
    input  logic          ins_all,
    input  logic [DW-1:0] pix,
    output lvl_e          lvl,
    output logic [DW-1:0] code
);
    localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] blank_code;
    logic          takes_sync;

    generate
        if (IS_GY) begin : g_luma
            assign blank_code = '0;
            assign takes_sync = 1'b1;
        end else begin : g_chroma
            assign blank_code = (FORCE_MID || ins_all) ? MID_CODE : '0;
            assign takes_sync = ins_all;
        end
    endgenerate

    always_comb begin
        if (sync_act) begin
            lvl  = takes_sync ? (sync_pos ? LVL_SYNC_POS : LVL_SYNC_NEG) : LVL_BLANK;
            code = blank_code;
        end else if (blank_act) begin
            lvl  = LVL_BLANK;
            code = blank_code;
        end else begin
            lvl  = LVL_VIDEO;
            code = pix;
        end
    end
endmodule

// File: rtl/sbc_align.sv
module sbc_align #(
    parameter int             W       = 30,
    parameter int             DEPTH   = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {DEPTH{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[DEPTH-1];
endmodule

// File: rtl/sync_blank_ctrl.sv
module sync_blank_ctrl
    import sbc_pkg::*;
#(
    parameter int DW        = 8,
    parameter int ALIGN_DLY = 2,
    parameter bit FORCE_MID = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blank_n,
    input  logic          sync_n,
    input  logic          sync_pos,
    input  logic          mode_pin,
    input  logic [DW-1:0] pix_gy,
    input  logic [DW-1:0] pix_pb,
    input  logic [DW-1:0] pix_pr,
    output logic [1:0]    lvl_gy,
    output logic [1:0]    lvl_pb,
    output logic [1:0]    lvl_pr,
    output logic [DW-1:0] code_gy,
    output logic [DW-1:0] code_pb,
    output logic [DW-1:0] code_pr,
    output logic          ins_all,
    output logic          mode_bit,
    output logic          cfg_valid
);
    localparam int SW = 2 + DW;
    localparam logic [SW-1:0]     SLOT_RST = {LVL_BLANK, {DW{1'b0}}};
    localparam logic [NCH*SW-1:0] BUS_RST  = {NCH{SLOT_RST}};

    typedef struct packed {
        logic                   blank_act;
        logic                   sync_act;
        logic                   pos;
        logic [NCH-1:0][DW-1:0] pix;
    } in_t;

    in_t in_d, in_q;

    always_comb begin
        in_d.blank_act  = ~blank_n;
        in_d.sync_act   = ~sync_n;
        in_d.pos        = sync_pos;
        in_d.pix[CH_GY] = pix_gy;
        in_d.pix[CH_PB] = pix_pb;
        in_d.pix[CH_PR] = pix_pr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '{blank_act: 1'b1, default: '0};
        end else begin
            in_q <= in_d;
        end
    end

    sbc_cfg_capture i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .mode_pin  (mode_pin),
        .ins_all   (ins_all),
        .mode_bit  (mode_bit),
        .cfg_valid (cfg_valid)
    );

    lvl_e                   lvl_dec [NCH];
    logic [NCH-1:0][DW-1:0] code_dec;
    logic [NCH-1:0][SW-1:0] dec_bus;
    logic [NCH-1:0][SW-1:0] out_bus;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            sbc_chan_sel #(
                .DW        (DW),
                .IS_GY     (ch == CH_GY),
                .FORCE_MID (FORCE_MID)
            ) i_sel (
                .sync_act  (in_q.sync_act),
                .sync_pos  (in_q.pos),
                .blank_act (in_q.blank_act),
                .ins_all   (ins_all),
                .pix       (in_q.pix[ch]),
                .lvl       (lvl_dec[ch]),
                .code      (code_dec[ch])
            );
            assign dec_bus[ch] = {lvl_dec[ch], code_dec[ch]};
        end
    endgenerate

    sbc_align #(
        .W       (NCH*SW),
        .DEPTH   (ALIGN_DLY),
        .RST_VAL (BUS_RST)
    ) i_align (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dec_bus),
        .dout  (out_bus)
    );

    assign {lvl_gy, code_gy} = out_bus[CH_GY];
    assign {lvl_pb, code_pb} = out_bus[CH_PB];
    assign {lvl_pr, code_pr} = out_bus[CH_PR];

    // R4: a captured sync request always yields a sync level on G/Y
    assert_gy_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_q.sync_act |-> (lvl_dec[CH_GY] inside {LVL_SYNC_NEG, LVL_SYNC_POS}));
    // R6: single-channel insertion keeps Pb at blank during sync
    assert_pb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_q.sync_act && !ins_all) |-> (lvl_dec[CH_PB] == LVL_BLANK));
    // R5: sync levels never appear outside a sync window
    assert_sync_only_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_q.sync_act |-> (!lvl_dec[CH_GY][1] && !lvl_dec[CH_PR][1]));
    // R7: G/Y carries code 0 whenever it is not at video level
    assert_gy_blank_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_gy != LVL_VIDEO) |-> (code_gy == '0));
endmodule

// File: tb/test_sync_blank_ctrl.sv
module test_sync_blank_ctrl;
    localparam int DW = 8;
    localparam int D  = 2;
    localparam int N  = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blank_n = 1'b0, sync_n = 1'b1, sync_pos = 1'b0, mode_pin = 1'b0;
    logic [DW-1:0] pix_gy = '0, pix_pb = '0, pix_pr = '0;
    logic [1:0] lvl_gy, lvl_pb, lvl_pr;
    logic [DW-1:0] code_gy, code_pb, code_pr;
    logic ins_all, mode_bit, cfg_valid;

    always #5 clk = ~clk;

    sync_blank_ctrl #(.DW(DW), .ALIGN_DLY(D), .FORCE_MID(1'b0)) i_sync_blank_ctrl (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .sync_n(sync_n),
        .sync_pos(sync_pos), .mode_pin(mode_pin),
        .pix_gy(pix_gy), .pix_pb(pix_pb), .pix_pr(pix_pr),
        .lvl_gy(lvl_gy), .lvl_pb(lvl_pb), .lvl_pr(lvl_pr),
        .code_gy(code_gy), .code_pb(code_pb), .code_pr(code_pr),
        .ins_all(ins_all), .mode_bit(mode_bit), .cfg_valid(cfg_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic vb [N], vs [N], vp [N], vins [N];
    logic [DW-1:0] vpix [N][3];
    int it = 0;

    logic m_ins = 1'b0, m_mode = 1'b0, m_valid = 1'b0;
    logic m_pend = 1'b0, m_prev_s = 1'b1, m_pend_rise = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] bcode(input int c, input logic ins);
        return (c == 0) ? 8'd0 : (ins ? 8'd128 : 8'd0);
    endfunction

    function automatic logic [1:0] exp_lvl(input int c, input int k);
        if (!vs[k]) return (c == 0 || vins[k]) ? (vp[k] ? 2'b11 : 2'b10) : 2'b01;
        if (!vb[k]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] exp_code(input int c, input int k);
        if (!vs[k] || !vb[k]) return bcode(c, vins[k]);
        return vpix[k][c];
    endfunction

    function automatic string lvl_tag(input int c, input int k);
        if (!vs[k]) return (c != 0 && !vins[k]) ? "R6" : (vp[k] ? "R5" : "R4");
        if (!vb[k]) return "R3";
        return vp[k] ? "R5" : "R2";
    endfunction

    task automatic check_out(input int k);
        logic [1:0] l [3];
        logic [DW-1:0] cd [3];
        l[0] = lvl_gy; l[1] = lvl_pb; l[2] = lvl_pr;
        cd[0] = code_gy; cd[1] = code_pb; cd[2] = code_pr;
        for (int c = 0; c < 3; c++) begin
            chk(lvl_tag(c, k), l[c], exp_lvl(c, k));
            chk((exp_lvl(c, k) == 2'b00) ? "R1" : "R7", cd[c], exp_code(c, k));
        end
    endtask

    task automatic step(input logic b, input logic s, input logic p, input logic m,
                        input logic [DW-1:0] g, input logic [DW-1:0] pb, input logic [DW-1:0] pr);
        @(negedge clk);
        if (it >= D + 1) check_out(it - D - 1);
        chk("R8", ins_all, m_ins);
        chk("R8", mode_bit, m_mode);
        chk("R10", cfg_valid, m_valid);
        if (m_pend) begin
            if (m_pend_rise) begin m_mode = m; m_valid = 1'b1; end
            else m_ins = m;
        end
        m_pend = (s != m_prev_s);
        m_pend_rise = s & ~m_prev_s;
        m_prev_s = s;
        vb[it] = b; vs[it] = s; vp[it] = p; vins[it] = m_ins;
        vpix[it][0] = g; vpix[it][1] = pb; vpix[it][2] = pr;
        blank_n = b; sync_n = s; sync_pos = p; mode_pin = m;
        pix_gy = g; pix_pb = pb; pix_pr = pr;
        it++;
    endtask

    initial begin
        logic s_now;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9", ins_all, 0);
        chk("R9", mode_bit, 0);
        chk("R9", cfg_valid, 0);
        chk("R9", lvl_gy, 1);
        chk("R9", lvl_pb, 1);
        chk("R9", code_pr, 0);

        // R2 video pass-through, R1 latency via unique pixels
        for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 8'h10 + 8'(i), 8'hA0 + 8'(i), 8'h50 + 8'(i));
        // R5: sync_pos ignored outside sync; R3 blanking
        step(1, 1, 1, 1, 8'hEE, 8'hDD, 8'hCC);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 8'hFF, 8'hFF, 8'hFF);
        // R8: falling sync, pin=1 on second edge -> ins_all=1
        step(0, 0, 0, 0, 8'h33, 8'h33, 8'h33);
        step(0, 0, 0, 1, 8'h33, 8'h33, 8'h33);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'h44, 8'h44, 8'h44);
        // R5 tri-level positive half, R6 all-channel insertion
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 8'h44, 8'h44, 8'h44);
        // R8/R10: rising sync, pin=1 -> mode_bit=1, cfg_valid=1
        step(0, 1, 0, 0, 8'h01, 8'h02, 8'h03);
        step(0, 1, 0, 1, 8'h01, 8'h02, 8'h03);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 8'h01, 8'h02, 8'h03);
        // R6: single-channel insertion with blank codes 0 (R7)
        step(1, 0, 0, 1, 8'h77, 8'h77, 8'h77);
        step(1, 0, 0, 0, 8'h77, 8'h77, 8'h77);
        for (int i = 0; i < 4; i++) step(1, 0, i[0], 1, 8'h77, 8'h77, 8'h77);
        step(1, 1, 0, 0, 8'h12, 8'h34, 8'h56);

        // constrained random
        s_now = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 11) == 0) s_now = ~s_now;
            step(($urandom_range(0, 3) != 0), s_now, 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom), 8'($urandom));
        end
        for (int i = 0; i < D + 2; i++) step(1, s_now, 0, 0, 8'h00, 8'h00, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule